// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block sits between a processor's register port and a 1 KB array of nonvolatile bytes, which is modelled here as an internal array with a long write latency. Software reaches the array through four byte-wide registers: a low and a high address register, a data register, and a control register. A read takes a single cycle. A write runs for a fixed number of cycles, and software can see that it is in progress through a busy bit.

Writes are protected by a two-step interlock. Software first sets an arming bit. The write strobe is accepted only if it arrives within a short window after that, so a single stray register write can never change the array. When a write is accepted, the controller captures the address and the data byte, counts out the write latency, commits the byte and then clears the busy bit by itself. If software enables it, a ready interrupt is raised whenever no write is pending.

The register port is plain control and status: one write per cycle, with read data driven combinationally from the selected register. It has no back-pressure, because every register write takes effect at the clock edge where it is presented.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset every register reads as zero and `ready_irq` is low.
- R2: Select 0 is the low address byte. Select 1 is the high address register, which keeps only its two least significant bits and reads its upper six bits as zero. The ten-bit array address is {high bits, low byte}.
- R3: Select 2 is the data register. A register write to it is read back unchanged on later cycles.
- R4: The control register is at select 3. Bit 0 is the read strobe and always reads as 0. Bit 1 is the write strobe, which reads back as busy. Bit 2 is the arming bit. Bit 3 is interrupt enable. Every write to the control register loads bit 3 into the interrupt enable.
- R5: A control write with bit 0 set while no write is busy loads the data register with the array byte at the current address. The new value is readable on the next cycle.
- R6: A read strobe issued while a write is busy leaves the data register unchanged.
- R7: A control write with bit 2 set arms the interlock. The arming bit reads 1 on the 4 cycles that follow that write and then clears without software action.
- R8: A control write with bit 1 set starts a write only when it lands 1 to 4 cycles after arming and no write is busy. A strobe later than that, a strobe without arming, or a strobe in the same write that sets the arming bit starts nothing. Starting a write clears the arming bit.
- R9: Once a write starts, busy stays set for WR_LAT (default 64) cycles and then clears. The array is updated with the address and data that were captured when the write started, so later register writes have no effect on what is stored.
- R10: A write strobe issued while busy is ignored, even when the interlock is armed. It does not lengthen the busy time.
- R11: `ready_irq` is high exactly when interrupt enable is set and no write is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe for this cycle |
| reg_sel | input | 2 | Register select (0 addr low, 1 addr high, 2 data, 3 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the selected register |
| ready_irq | output | 1 | Ready interrupt: enabled and not busy |

## Verification
On every cycle, the embedded properties check the following. A write can only begin after the interlock was armed. The array is only written while busy. A busy period never ends before its commit. A read strobe during a write leaves the data register alone. The interrupt never shows while busy. The high address register never exposes bits above its two. The exact window edges need the bench's scenarios: a strobe on the fourth cycle after arming against one on the fifth, arm and strobe in the same write, and a strobe during busy. So do the full 64-cycle busy length and the proof that the captured address and data, rather than later register values, reach the array.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_ALO = 2'd0,
    SEL_AHI = 2'd1,
    SEL_DAT = 2'd2,
    SEL_CTL = 2'd3
  } nvm_sel_e;

  localparam int CB_RD  = 0;
  localparam int CB_WR  = 1;
  localparam int CB_ARM = 2;
  localparam int CB_IE  = 3;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic armed_o
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            left_q <= '0;
    else if (clr_i)        left_q <= '0;
    else if (set_i)        left_q <= CW'(WIN);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign armed_o = (left_q != '0);

  // R7
  arm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !set_i) |=> !armed_o);
endmodule

// File: rtl/nvm_wr_engine.sv
module nvm_wr_engine #(
  parameter int AW  = 10,
  parameter int DW  = 8,
  parameter int LAT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic [AW-1:0] caddr_o,
  output logic [DW-1:0] cdata_o
);
  localparam int LW = $clog2(LAT + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      caddr_o <= '0;
      cdata_o <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else if (start_i) begin
      left_q  <= LW'(LAT);
      caddr_o <= addr_i;
      cdata_o <= data_i;
    end
  end

  assign busy_o   = (left_q != '0);
  assign commit_o = (left_q == LW'(1));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !commit_o) |=> busy_o);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(commit_o));
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int WR_LAT  = 64,
  parameter int ARM_WIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ready_irq
);
  import nvm_pkg::*;

  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] alo_q;
  logic [HI_W-1:0]   ahi_q;
  logic [DATA_W-1:0] dat_q;
  logic              ie_q;

  logic              ctl_wr, fire, rd_go, armed, busy, st_we;
  logic [ADDR_W-1:0] cur_addr, st_waddr;
  logic [DATA_W-1:0] st_wdata, st_rdata;

  assign cur_addr = {ahi_q, alo_q};
  assign ctl_wr   = reg_we && (nvm_sel_e'(reg_sel) == SEL_CTL);
  assign fire     = ctl_wr && reg_wdata[CB_WR] && armed && !busy;
  assign rd_go    = ctl_wr && reg_wdata[CB_RD] && !busy;

  nvm_arm_window #(.WIN(ARM_WIN)) u_arm (
    .clk(clk), .rst_n(rst_n),
    .set_i(ctl_wr && reg_wdata[CB_ARM]), .clr_i(fire),
    .armed_o(armed)
  );

  nvm_wr_engine #(.AW(ADDR_W), .DW(DATA_W), .LAT(WR_LAT)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(fire),
    .addr_i(cur_addr), .data_i(dat_q),
    .busy_o(busy), .commit_o(st_we),
    .caddr_o(st_waddr), .cdata_o(st_wdata)
  );

  nvm_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .we_i(st_we), .waddr_i(st_waddr), .wdata_i(st_wdata),
    .raddr_i(cur_addr), .rdata_o(st_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alo_q <= '0;
      ahi_q <= '0;
      dat_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      if (reg_we) begin
        unique case (nvm_sel_e'(reg_sel))
          SEL_ALO: alo_q <= reg_wdata;
          SEL_AHI: ahi_q <= reg_wdata[HI_W-1:0];
          SEL_DAT: dat_q <= reg_wdata;
          SEL_CTL: ie_q  <= reg_wdata[CB_IE];
        endcase
      end
      if (rd_go) dat_q <= st_rdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (nvm_sel_e'(reg_sel))
      SEL_ALO: reg_rdata = alo_q;
      SEL_AHI: reg_rdata[HI_W-1:0] = ahi_q;
      SEL_DAT: reg_rdata = dat_q;
      SEL_CTL: begin
        reg_rdata[CB_WR]  = busy;
        reg_rdata[CB_ARM] = armed;
        reg_rdata[CB_IE]  = ie_q;
      end
    endcase
  end

  assign ready_irq = ie_q && !busy;

  // R8
  fire_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  // R9
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> busy);
  // R6
  rd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[CB_RD] && busy) |=> $stable(dat_q));
  // R11
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_irq |-> !reg_rdata[CB_WR] || (nvm_sel_e'(reg_sel) != SEL_CTL));
  // R2
  ahi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_sel_e'(reg_sel) == SEL_AHI) |-> ((reg_rdata >> HI_W) == '0));
endmodule

// File: tb/nvm_access_ctrl_bench.sv
module nvm_access_ctrl_bench;
  localparam int LAT = 64;
  localparam int WIN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ready_irq;

  always #2.5 clk = ~clk;

  nvm_access_ctrl #(.WR_LAT(LAT), .ARM_WIN(WIN)) u_nvm_access_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ready_irq(ready_irq)
  );

  int vectors = 0;
  int miscompares = 0;
  int irq_low_cnt = 0;
  string cur_req = "R1";

  // behavioural reference state
  byte unsigned m_mem [1024];
  int m_lo, m_hi, m_dat, m_ie, m_arm, m_wr, m_waddr, m_wdata;

  function automatic int exp_rdata(input int sel);
    case (sel)
      0: return m_lo;
      1: return m_hi;
      2: return m_dat;
      default: return (m_ie << 3) | ((m_arm > 0) << 2) | ((m_wr > 0) << 1);
    endcase
  endfunction

  task automatic model_clock(input bit we, input int sel, input int wd);
    bit ctl, fire, rdg;
    int addr;
    addr = (m_hi << 8) | m_lo;
    ctl  = we && sel == 3;
    fire = ctl && wd[1] && m_arm > 0 && m_wr == 0;
    rdg  = ctl && wd[0] && m_wr == 0;
    if (fire) m_arm = 0;
    else if (ctl && wd[2]) m_arm = WIN;
    else if (m_arm > 0) m_arm--;
    if (m_wr > 0) begin
      if (m_wr == 1) m_mem[m_waddr] = byte'(m_wdata);
      m_wr--;
    end else if (fire) begin
      m_wr = LAT; m_waddr = addr; m_wdata = m_dat;
    end
    if (we) begin
      case (sel)
        0: m_lo = wd & 8'hFF;
        1: m_hi = wd & 3;
        2: m_dat = wd & 8'hFF;
        default: m_ie = (wd >> 3) & 1;
      endcase
    end
    if (rdg) m_dat = m_mem[addr];
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input int sel, input int wd, output int seen);
    reg_we = we; reg_sel = 2'(sel); reg_wdata = 8'(wd);
    #1;
    seen = reg_rdata;
    chk({cur_req, " rdata"}, reg_rdata, exp_rdata(sel));
    chk({cur_req, " irq"}, ready_irq, m_ie && m_wr == 0);
    if (!ready_irq) irq_low_cnt++;
    @(posedge clk);
    model_clock(we, sel, wd);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int s;
    for (int k = 0; k < 300; k++) begin
      step(0, 3, 0, s);
      if (!s[1]) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int s;
    for (int i = 0; i < 1024; i++) m_mem[i] = 0;
    m_lo = 0; m_hi = 0; m_dat = 0; m_ie = 0; m_arm = 0; m_wr = 0;
    m_waddr = 0; m_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    for (int r = 0; r < 4; r++) begin step(0, r, 0, s); chk("R1 reset reg", s, 0); end

    cur_req = "R11";
    step(1, 3, 8'h08, s);
    step(0, 3, 0, s); chk("R11 irq enabled idle", ready_irq, 1);

    cur_req = "R2";
    step(1, 1, 8'hFF, s);
    step(0, 1, 0, s); chk("R2 high addr two bits", s, 8'h03);
    step(1, 1, 8'h02, s);
    step(1, 0, 8'hF3, s);
    cur_req = "R3";
    step(1, 2, 8'hA5, s);
    step(0, 2, 0, s); chk("R3 data readback", s, 8'hA5);

    cur_req = "R7";
    step(1, 3, 8'h0C, s);
    step(0, 3, 0, s); chk("R7 armed", s, 8'h0C);
    cur_req = "R8";
    step(1, 3, 8'h0A, s);
    irq_low_cnt = 0;
    step(0, 3, 0, s); chk("R8 busy after armed strobe", s, 8'h0A);
    chk("R11 irq low while busy", ready_irq, 0);

    cur_req = "R6";
    step(1, 2, 8'h11, s);
    step(1, 0, 8'h00, s);
    step(1, 3, 8'h09, s);
    step(0, 2, 0, s); chk("R6 read while busy ignored", s, 8'h11);
    cur_req = "R10";
    step(1, 3, 8'h0C, s);
    step(1, 3, 8'h0A, s);
    wait_idle();
    chk("R9 R10 busy length", irq_low_cnt, LAT);

    cur_req = "R5";
    step(1, 0, 8'hF3, s);
    step(1, 3, 8'h09, s);
    step(0, 2, 0, s); chk("R5 R9 captured byte stored", s, 8'hA5);

    cur_req = "R8";
    step(1, 1, 8'h00, s);
    step(1, 0, 8'h10, s);
    step(1, 2, 8'h3C, s);
    step(1, 3, 8'h0C, s);
    for (int k = 0; k < 3; k++) step(0, 3, 0, s);
    step(1, 3, 8'h0A, s);
    step(0, 3, 0, s); chk("R8 strobe on fourth cycle accepted", s[1], 1);
    wait_idle();
    step(1, 3, 8'h09, s);
    step(0, 2, 0, s); chk("R5 read second byte", s, 8'h3C);

    step(1, 2, 8'h77, s);
    step(1, 3, 8'h0C, s);
    for (int k = 0; k < 4; k++) step(0, 3, 0, s);
    cur_req = "R7";
    step(1, 3, 8'h0A, s); chk("R7 arm expired", s[2], 0);
    cur_req = "R8";
    step(0, 3, 0, s); chk("R8 late strobe ignored", s[1], 0);
    step(1, 3, 8'h09, s);
    step(0, 2, 0, s); chk("R8 array unchanged", s, 8'h3C);

    step(1, 3, 8'h0A, s);
    step(0, 3, 0, s); chk("R8 unarmed strobe ignored", s, 8'h08);
    step(1, 3, 8'h0E, s);
    step(0, 3, 0, s); chk("R8 same-write arm and strobe", s, 8'h0C);

    cur_req = "R11";
    step(1, 3, 8'h00, s);
    step(0, 3, 0, s); chk("R11 irq disabled", ready_irq, 0);
    cur_req = "R4";
    step(1, 3, 8'h09, s);
    step(0, 3, 0, s); chk("R4 read strobe reads zero", s[0], 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule